// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital control section of a 128-position digitally trimmed potentiometer. A host drives three asynchronous pins. `selN` is an active-low select. `stepN` is a strobe that acts on its falling edge. `dirUp` sets the direction. The block samples all three into the system clock domain and keeps a saturating wiper position. It decodes that position onto a one-hot tap-select bus that drives the analog switch network.

When the host deselects, the level of the strobe at that moment sets what happens. If the strobe is high, the block commits the position to a behavioural nonvolatile register, using a self-timed write interval. If the strobe is low, the host leaves without committing anything. The saved value is reloaded into the wiper after every reset. The nonvolatile register has its own first-power initialisation input, which loads the mid-scale default, so its contents survive ordinary resets.

A `busy` output is high throughout the write interval. A `standby` output marks the idle, deselected state.

Top module: `wiper_ctl_top`

## Requirements
- R1: `tapSel` has exactly one bit set at all times after reset, and that bit is at index `wiperPos` (7-bit position, 128 taps).
- R2: While `selN` is high, edges on `stepN` and changes on `dirUp` leave `wiperPos` unchanged.
- R3: While selected, each high-to-low transition of `stepN` moves `wiperPos` by one: up by one when `dirUp` is 1, down by one when `dirUp` is 0.
- R4: The position saturates. An up step at 127 leaves it at 127, and a down step at 0 leaves it at 0.
- R5: A rising edge of `selN` while `stepN` is high commits the current position to the nonvolatile register. A rising edge of `selN` while `stepN` is low leaves the register unchanged.
- R6: A commit keeps `busy` high for exactly `STORE_CYCLES` clock cycles. During that time, activity on `selN` and `stepN` changes neither the position nor the value being committed.
- R7: After a commit completes, or after a deselect without commit, `standby` is 1 and `busy` is 0. The block stays in standby until `selN` goes low.
- R8: After `rstN` is released, `wiperPos` is reloaded from the nonvolatile register. After `nvInitN` is asserted, that register holds `NV_DEFAULT` (63).
- R9: `dirUp` may change while `selN` stays low, so one selection can contain both up and down steps.
- R10: If `selN` falls while `busy` is high, the selection takes effect only after the commit finishes. The block then leaves standby and accepts steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset of the control logic (models a power cycle) |
| nvInitN | input | 1 | Active-low first-power initialisation of the nonvolatile register |
| selN | input | 1 | Asynchronous active-low select |
| stepN | input | 1 | Asynchronous step strobe, acts on its falling edge |
| dirUp | input | 1 | Asynchronous direction level, 1 = up |
| wiperPos | output | 7 | Current wiper position |
| tapSel | output | 128 | One-hot tap select |
| busy | output | 1 | Nonvolatile write in progress |
| standby | output | 1 | Idle and deselected |

## Verification
The bench builds the block with the default 128 taps and a default value of 63. It sets `STORE_CYCLES` to 40 instead of a full 20 ms at 50 MHz. The short write interval lets it measure the exact busy length and inject strobe and select activity inside a commit. It can also run several commit-then-power-cycle rounds well within the cycle limit. The full tap count keeps both saturation ends and the top tap-select line reachable within a few hundred step pulses.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // copy saved value into the wiper counter
    logic stepUp;    // increment with saturation
    logic stepDown;  // decrement with saturation
    logic commit;    // write wiper counter into the nonvolatile register
  } wiperCmd_t;

  typedef enum logic [1:0] {
    ST_RECALL  = 2'd0,
    ST_STANDBY = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_STORE   = 2'd3
  } ctrlState_t;

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  // Two flops per line into the clock domain
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta;
    logic stable;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta   <= RST_VAL[b];
        stable <= RST_VAL[b];
      end else begin
        meta   <= asyncIn[b];
        stable <= meta;
      end
    end
    assign syncOut[b] = stable;
  end

endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int unsigned STORE_CYCLES = 1000000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      selS,
  input  logic      stepS,
  input  logic      dirS,
  output wiperCmd_t cmd,
  output logic      busy,
  output logic      standby
);

  localparam int TIMER_W = $clog2(STORE_CYCLES + 1);
  localparam logic [TIMER_W-1:0] LAST = TIMER_W'(STORE_CYCLES - 1);

  ctrlState_t state, nextState;
  logic [TIMER_W-1:0] timer;
  logic stepPrev;
  logic stepFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepPrev <= 1'b1;
    else       stepPrev <= stepS;
  end

  assign stepFall = stepPrev & ~stepS;

  always_comb begin
    cmd       = '0;
    nextState = state;
    unique case (state)
      ST_RECALL: begin
        cmd.load  = 1'b1;
        nextState = ST_STANDBY;
      end
      ST_STANDBY: begin
        if (!selS) nextState = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (selS) begin
          // The strobe level at deselect decides commit or plain exit
          nextState = stepS ? ST_STORE : ST_STANDBY;
        end else if (stepFall) begin
          cmd.stepUp   = dirS;
          cmd.stepDown = ~dirS;
        end
      end
      ST_STORE: begin
        if (timer == LAST) begin
          cmd.commit = 1'b1;
          nextState  = ST_STANDBY;
        end
      end
      default: nextState = ST_RECALL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RECALL;
      timer <= '0;
    end else begin
      state <= nextState;
      if (state == ST_STORE) timer <= timer + 1'b1;
      else                   timer <= '0;
    end
  end

  assign busy    = (state == ST_STORE);
  assign standby = (state == ST_STANDBY);

  // R6: no movement or reload while the write runs
  p_quiet_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(cmd.stepUp || cmd.stepDown || cmd.load));

  // R2: a deselected host never moves the wiper
  p_ignore_desel_r2: assert property (@(posedge clk) disable iff (!rstN)
    selS |-> !(cmd.stepUp || cmd.stepDown));

  // R6: the write interval is not cut short
  p_store_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STORE && timer != LAST) |=> busy);

  // R7: a finished write always lands in standby
  p_commit_standby_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |=> (standby && !busy));

endmodule

// File: rtl/wiper_datapath.sv
module wiper_datapath
  import wiper_pkg::*;
#(
  parameter int TAPS = 128,
  parameter int NV_DEFAULT = 63
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     nvInitN,
  input  wiperCmd_t                cmd,
  output logic [$clog2(TAPS)-1:0]  pos,
  output logic [TAPS-1:0]          tapSel
);

  localparam int POS_W = $clog2(TAPS);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(TAPS - 1);

  logic [POS_W-1:0] count;
  logic [POS_W-1:0] nvValue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (cmd.load) begin
      count <= nvValue;
    end else if (cmd.stepUp && count != POS_MAX) begin
      count <= count + 1'b1;
    end else if (cmd.stepDown && count != '0) begin
      count <= count - 1'b1;
    end
  end

  // Behavioural nonvolatile cell: only first-power init clears it
  always_ff @(posedge clk or negedge nvInitN) begin
    if (!nvInitN)        nvValue <= POS_W'(NV_DEFAULT);
    else if (cmd.commit) nvValue <= count;
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tapSel[t] = (count == POS_W'(t));
  end

  assign pos = count;

  // R4: saturation at the top
  p_sat_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepUp && count == POS_MAX) |=> count == POS_MAX);

  // R4: saturation at the bottom
  p_sat_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepDown && count == '0) |=> count == '0);

  // R3: single-step increment
  p_step_up_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepUp && !cmd.load && count != POS_MAX) |=> count == $past(count) + 1'b1);

  // R1: exactly one tap selected, at the counter value
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(tapSel) == 1) && tapSel[count]);

endmodule

// File: rtl/wiper_ctl_top.sv
module wiper_ctl_top
  import wiper_pkg::*;
#(
  parameter int TAPS = 128,
  parameter int unsigned STORE_CYCLES = 1000000,
  parameter int NV_DEFAULT = 63
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    nvInitN,
  input  logic                    selN,
  input  logic                    stepN,
  input  logic                    dirUp,
  output logic [$clog2(TAPS)-1:0] wiperPos,
  output logic [TAPS-1:0]         tapSel,
  output logic                    busy,
  output logic                    standby
);

  logic [2:0] syncd;
  wiperCmd_t  cmd;

  wiper_sync #(.WIDTH(3), .RST_VAL(3'b110)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({selN, stepN, dirUp}),
    .syncOut (syncd)
  );

  wiper_ctrl #(.STORE_CYCLES(STORE_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .selS    (syncd[2]),
    .stepS   (syncd[1]),
    .dirS    (syncd[0]),
    .cmd     (cmd),
    .busy    (busy),
    .standby (standby)
  );

  wiper_datapath #(.TAPS(TAPS), .NV_DEFAULT(NV_DEFAULT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .nvInitN (nvInitN),
    .cmd     (cmd),
    .pos     (wiperPos),
    .tapSel  (tapSel)
  );

endmodule

// File: tb/tb_wiper_ctl_top.sv
module tb_wiper_ctl_top;

  localparam int TAPS = 128;
  localparam int STORE_CYCLES = 40;

  logic clk = 1'b0;
  logic rstN, nvInitN, selN, stepN, dirUp;
  logic [6:0] wiperPos;
  logic [TAPS-1:0] tapSel;
  logic busy, standby;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // Each entry: {direction, expected position after the step}
  localparam logic [7:0] VEC [8] = '{
    {1'b1, 7'd64}, {1'b1, 7'd65}, {1'b1, 7'd66}, {1'b0, 7'd65},
    {1'b0, 7'd64}, {1'b0, 7'd63}, {1'b0, 7'd62}, {1'b1, 7'd63}
  };

  wiper_ctl_top #(.TAPS(TAPS), .STORE_CYCLES(STORE_CYCLES), .NV_DEFAULT(63)) dut (
    .clk(clk), .rstN(rstN), .nvInitN(nvInitN), .selN(selN), .stepN(stepN),
    .dirUp(dirUp), .wiperPos(wiperPos), .tapSel(tapSel), .busy(busy), .standby(standby)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkPos(input int exp, input string req);
    check(wiperPos == 7'(exp), req, int'(wiperPos), exp);
    check(tapSel == (128'd1 << exp), {req, " R1 tap"}, $countones(tapSel), 1);
  endtask

  task automatic pulseStep(input logic d);
    dirUp = d;  waitN(4);
    stepN = 1'b0; waitN(5);
    stepN = 1'b1; waitN(5);
  endtask

  task automatic stepHold(input logic d);
    dirUp = d;  waitN(4);
    stepN = 1'b0; waitN(5);
  endtask

  task automatic powerCycle();
    rstN = 1'b0; waitN(3);
    rstN = 1'b1; waitN(6);
  endtask

  initial begin
    int busyLen;
    selN = 1'b1; stepN = 1'b1; dirUp = 1'b0;
    rstN = 1'b0; nvInitN = 1'b0;
    waitN(3);
    rstN = 1'b1; nvInitN = 1'b1;
    waitN(6);

    // Reset state: default recalled, standby
    checkPos(63, "R8 default recall");
    check(standby == 1'b1, "R7 standby after reset", int'(standby), 1);
    check(busy == 1'b0, "R6 idle after reset", int'(busy), 0);

    // Table walk: mixed up/down steps in one selection (R3, R9)
    selN = 1'b0; waitN(5);
    check(standby == 1'b0, "R7 leave standby on select", int'(standby), 0);
    for (int i = 0; i < 8; i++) begin
      pulseStep(VEC[i][7]);
      checkPos(int'(VEC[i][6:0]), "R3 R9 table step");
    end

    // Deselect without commit (R5, R7)
    stepHold(1'b1);
    checkPos(64, "R3 step before exit");
    selN = 1'b1; waitN(6);
    check(standby == 1'b1, "R7 standby after plain exit", int'(standby), 1);
    check(busy == 1'b0, "R5 no write on plain exit", int'(busy), 0);
    stepN = 1'b1; waitN(5);

    // Strobes while deselected are ignored (R2)
    pulseStep(1'b1);
    pulseStep(1'b0);
    pulseStep(1'b0);
    checkPos(64, "R2 deselected steps ignored");

    powerCycle();
    checkPos(63, "R5 R8 plain exit kept saved value");

    // Saturation (R4)
    selN = 1'b0; waitN(5);
    for (int i = 0; i < 66; i++) pulseStep(1'b1);
    checkPos(127, "R4 reach top");
    pulseStep(1'b1);
    checkPos(127, "R4 hold at top");
    for (int i = 0; i < 127; i++) pulseStep(1'b0);
    checkPos(0, "R4 reach bottom");
    pulseStep(1'b0);
    checkPos(0, "R4 hold at bottom");
    for (int i = 0; i < 5; i++) pulseStep(1'b1);
    checkPos(5, "R3 climb from bottom");

    // Commit and measure write length (R5, R6, R7)
    selN = 1'b1;
    busyLen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (busy) busyLen++;
    end
    check(busyLen == STORE_CYCLES, "R6 write length", busyLen, STORE_CYCLES);
    check(standby == 1'b1, "R7 standby after write", int'(standby), 1);
    powerCycle();
    checkPos(5, "R5 R8 committed value recalled");

    // Commit with activity inside it and early select (R6, R10)
    selN = 1'b0; waitN(5);
    pulseStep(1'b1);
    checkPos(6, "R3 step before second write");
    selN = 1'b1; waitN(8);
    check(busy == 1'b1, "R6 busy during write", int'(busy), 1);
    stepN = 1'b0; waitN(3);
    stepN = 1'b1; waitN(3);
    selN = 1'b0; waitN(6);
    check(busy == 1'b1, "R10 select held off while busy", int'(busy), 1);
    check(standby == 1'b0, "R10 not standby while busy", int'(standby), 0);
    checkPos(6, "R6 activity during write ignored");
    for (int i = 0; i < STORE_CYCLES + 20; i++) begin
      if (busy) @(negedge clk);
    end
    waitN(5);
    check(busy == 1'b0, "R6 write ended", int'(busy), 0);
    check(standby == 1'b0, "R10 selected after write", int'(standby), 0);
    pulseStep(1'b1);
    checkPos(7, "R10 steps accepted after write");
    stepHold(1'b0);
    checkPos(6, "R9 reverse within selection");
    stepHold(1'b1);
    selN = 1'b1; waitN(6);
    stepN = 1'b1; waitN(5);
    powerCycle();
    checkPos(6, "R5 R6 value committed despite activity");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule